// File: doc/BRIEF.md
# Bypass-capable synchronous FIFO

A single-clock first-in first-out buffer with a valid/ready handshake on both sides. Each entry carries a data word and a narrow sideband word, and both leave together and in order. The storage depth is a parameter from 0 to 16 entries, with 2 as the default.

A second parameter enables a combinational bypass. When it is set and the buffer is empty, an arriving item is presented at the output in the same cycle. If the consumer takes it, the item never touches storage. When the bypass is off, every item spends at least one cycle in a register. With the bypass on, a depth of zero is allowed, and the block then reduces to plain wires. A request buffer and a response buffer built from this block can be placed side by side to decouple two ends of a bus.

Top module: `bypass_fifo`

## Requirements
- R1: With PASS=1 and nothing stored, a valid input appears on the output in the same cycle: out_valid is 1, and out_data/out_side equal in_data/in_side.
- R2: With PASS=0, out_valid is 0 whenever nothing is stored, so every item takes at least one clock edge from input to output.
- R3: The bypass is used only when out_ready is 1 in that cycle. Otherwise an accepted item is written to storage and later leaves from there.
- R4: Items leave in the order they were accepted, and each sideband word stays with its data word.
- R5: in_ready is 1 whenever occupancy is below DEPTH. When storage is full it is 0, unless PASS=1 and out_ready=1.
- R6: With PASS=1, storage full and out_ready=1, a push and a pop happen in the same cycle and the occupancy stays the same.
- R7: With DEPTH=0 and PASS=1, out_valid equals in_valid, in_ready equals out_ready, and the output word equals the input word.
- R8: DEPTH may be any value from 0 to 16. DEPTH=0 together with PASS=0 is rejected at elaboration.
- R9: Asserting the asynchronous active-low reset discards all stored items. While no input is valid, out_valid is then 0.
- R10: While a stored head item is offered and out_ready is 0, out_valid stays 1 and the output word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers an item |
| in_ready | output | 1 | Buffer accepts the offered item this cycle |
| in_data | input | DATA_W | Data word of the offered item |
| in_side | input | SIDE_W | Sideband word of the offered item |
| out_valid | output | 1 | An item is offered to the consumer |
| out_ready | input | 1 | Consumer takes the offered item this cycle |
| out_data | output | DATA_W | Data word of the offered item |
| out_side | output | SIDE_W | Sideband word of the offered item |

## Verification
On every cycle, the assertions track occupancy from the port handshakes. Against that count they check the same-cycle bypass, the absence of early output when the bypass is off, the full/not-full ready rules including simultaneous push and pop, and that a stalled head stays stable. Data ordering, the pairing of sideband and data, the choice between bypass and storage when the consumer stalls, reset in the middle of a fill, and the pure-wire variant can only be shown by the bench's scenarios. These compare the output stream against a queue model for depths 0, 1, 2 and 16 with both bypass settings under random stalls.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

   // Largest storage depth the block supports.
   localparam int unsigned DEPTH_LIMIT = 16;

   // Width of an index into n entries, never below one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Width of a counter holding values 0..n, never below one bit.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 0) ? $clog2(n + 1) : 1;
   endfunction

endpackage

// File: rtl/bfifo_store.sv
module bfifo_store #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 2,
   parameter int unsigned PTR_W = 1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [PTR_W-1:0] waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [PTR_W-1:0] raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] slot_q [DEPTH];

   // One write-enabled register per entry; data storage needs no reset.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we && (waddr == PTR_W'(i))) begin
            slot_q[i] <= wdata;
         end
      end
   end

   assign rdata = slot_q[raddr];

endmodule

// File: rtl/bfifo_occ_ctrl.sv
module bfifo_occ_ctrl #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned PTR_W = 1,
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             empty,
   output logic             full
);

   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) begin
            wr_q <= step(wr_q);
         end
         if (pop) begin
            rd_q <= step(rd_q);
         end
         if (push && !pop) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end else if (pop && !push) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign wr_ptr = wr_q;
   assign rd_ptr = rd_q;
   assign empty  = (cnt_q == '0);
   assign full   = (cnt_q == CNT_FULL);

endmodule

// File: rtl/bypass_fifo.sv
module bypass_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SIDE_W = 1,
   parameter int unsigned DEPTH  = 2,
   parameter bit          PASS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic [SIDE_W-1:0] in_side,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [SIDE_W-1:0] out_side
);

   import bfifo_pkg::*;

   localparam int unsigned ENTRY_W = DATA_W + SIDE_W;

   // R8: parameter range checks at elaboration
   if (DEPTH > DEPTH_LIMIT) begin : g_bad_depth
      $error("bypass_fifo: DEPTH above supported limit");
   end
   if ((DEPTH == 0) && !PASS) begin : g_bad_zero
      $error("bypass_fifo: zero depth requires PASS");
   end
   if ((DATA_W == 0) || (SIDE_W == 0)) begin : g_bad_width
      $error("bypass_fifo: word widths must be nonzero");
   end

   logic [ENTRY_W-1:0] entry_in, entry_out;

   assign entry_in              = {in_side, in_data};
   assign {out_side, out_data}  = entry_out;

   if (DEPTH == 0) begin : g_wire
      // R7: no storage, direct connection
      assign out_valid = in_valid;
      assign in_ready  = out_ready;
      assign entry_out = entry_in;
   end else begin : g_buf
      localparam int unsigned PTR_W = idx_width(DEPTH);
      localparam int unsigned CNT_W = cnt_width(DEPTH);

      logic             push, pop, empty, full;
      logic [PTR_W-1:0] wr_ptr, rd_ptr;
      logic [ENTRY_W-1:0] head;

      bfifo_occ_ctrl #(
         .DEPTH (DEPTH),
         .PTR_W (PTR_W),
         .CNT_W (CNT_W)
      ) u_ctrl (
         .clk    (clk),
         .rst_n  (rst_n),
         .push   (push),
         .pop    (pop),
         .wr_ptr (wr_ptr),
         .rd_ptr (rd_ptr),
         .empty  (empty),
         .full   (full)
      );

      bfifo_store #(
         .WIDTH (ENTRY_W),
         .DEPTH (DEPTH),
         .PTR_W (PTR_W)
      ) u_store (
         .clk   (clk),
         .we    (push),
         .waddr (wr_ptr),
         .wdata (entry_in),
         .raddr (rd_ptr),
         .rdata (head)
      );

      if (PASS) begin : g_pass
         logic skip;
         // An empty buffer with a taking consumer lets the item skip storage.
         assign skip      = empty && out_ready;
         assign out_valid = !empty || in_valid;
         assign entry_out = empty ? entry_in : head;
         assign in_ready  = !full || out_ready;
         assign push      = in_valid && in_ready && !skip;
         assign pop       = !empty && out_ready;
      end else begin : g_reg
         assign out_valid = !empty;
         assign entry_out = head;
         assign in_ready  = !full;
         assign push      = in_valid && !full;
         assign pop       = !empty && out_ready;
      end
   end

endmodule

// File: rtl/bypass_fifo_chk.sv
module bypass_fifo_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SIDE_W = 1,
   parameter int unsigned DEPTH  = 2,
   parameter bit          PASS   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic [SIDE_W-1:0] in_side,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic [SIDE_W-1:0] out_side
);

   // Occupancy seen from the port handshakes alone.
   logic [5:0] occ;
   logic       took_in, gave_out;

   assign took_in  = in_valid && in_ready;
   assign gave_out = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ <= '0;
      end else if (took_in && !gave_out) begin
         occ <= occ + 6'd1;
      end else if (gave_out && !took_in) begin
         occ <= occ - 6'd1;
      end
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(occ) <= DEPTH);

   // R9
   empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) && !in_valid |-> !out_valid);

   // R5
   ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(occ) < DEPTH) |-> in_ready);

   // R10
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && (occ != '0)
      |=> out_valid && $stable(out_data) && $stable(out_side));

   if (PASS) begin : g_pass_chk
      // R1
      bypass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (occ == '0) && in_valid
         |-> out_valid && (out_data == in_data) && (out_side == in_side));
      // R6
      full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(occ) == DEPTH) && out_ready |-> in_ready);
      // R5
      full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(occ) == DEPTH) && !out_ready |-> !in_ready);
   end else begin : g_reg_chk
      // R2
      no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (occ == '0) |-> !out_valid);
      // R5
      full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(occ) == DEPTH) |-> !in_ready);
   end

endmodule

bind bypass_fifo bypass_fifo_chk #(
   .DATA_W (DATA_W),
   .SIDE_W (SIDE_W),
   .DEPTH  (DEPTH),
   .PASS   (PASS)
) u_bypass_fifo_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .in_side   (in_side),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_side  (out_side)
);

// File: tb/bypass_fifo_bench.sv
`timescale 1ns/1ps
module bypass_fifo_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_rst_n = 1'b0;
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // ---------------- directed instance: DEPTH 2, PASS 1 ----------------
   logic       mv, mr, ms, m_ir, m_ov, m_os;
   logic [7:0] md, m_od;

   bypass_fifo #(.DATA_W(8), .SIDE_W(1), .DEPTH(2), .PASS(1'b1)) u_bypass_fifo (
      .clk(clk), .rst_n(m_rst_n),
      .in_valid(mv), .in_ready(m_ir), .in_data(md), .in_side(ms),
      .out_valid(m_ov), .out_ready(mr), .out_data(m_od), .out_side(m_os)
   );

   // {in_valid, out_ready, exp in_ready, exp out_valid, exp out_data}; input data is 0x10+step
   localparam logic [11:0] TBL [12] = '{
      12'hF10,  // R1 bypass on empty
      12'hB11,  // R3 consumer stalled: stored, still shown
      12'hB11,  // R10 head held
      12'h911,  // R5 full, consumer stalled: not ready
      12'hF11,  // R6 full push and pop
      12'h712,  // R4 order
      12'h714,  // R4 order
      12'h600,  // empty idle
      12'hB18,  // R3 stored
      12'hF18,  // push and pop with one stored
      12'h719,  // R4
      12'h200   // idle
   };

   // ---------------- stream instances over several configurations ----------------
   localparam int NCFG = 7;
   localparam int CFG_DEPTH [NCFG] = '{0, 1, 1, 2, 2, 16, 16};
   localparam bit CFG_PASS  [NCFG] = '{1, 0, 1, 0, 1, 0, 1};
   bit g_done [NCFG];

   for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      localparam int D = CFG_DEPTH[g];
      localparam bit P = CFG_PASS[g];
      logic       sv, sr, ss, s_ir, s_ov, s_os;
      logic [7:0] sd, s_od;
      logic [8:0] model [$];

      bypass_fifo #(.DATA_W(8), .SIDE_W(1), .DEPTH(D), .PASS(P)) u_dut (
         .clk(clk), .rst_n(rst_n),
         .in_valid(sv), .in_ready(s_ir), .in_data(sd), .in_side(ss),
         .out_valid(s_ov), .out_ready(sr), .out_data(s_od), .out_side(s_os)
      );

      initial begin
         logic [7:0] seq;
         logic [8:0] exp_w;
         seq = 8'd0;
         sv = 1'b0; sr = 1'b0; sd = '0; ss = 1'b0;
         wait (rst_n);
         @(negedge clk);
         for (int c = 0; c < 460; c++) begin
            if (c < 400) begin
               sv = ($urandom_range(0, 3) != 0);
               sr = ($urandom_range(0, 2) != 0);
            end else begin
               sv = 1'b0;
               sr = 1'b1;
            end
            sd = seq;
            ss = seq[2] ^ seq[5];
            #1;
            if (model.size() < D) chk(s_ir == 1'b1, "R5 ready below depth", 32'(s_ir), 32'd1);
            if (D == 0) begin
               chk(s_ir == sr, "R7 ready wire", 32'(s_ir), 32'(sr));
               chk(s_ov == sv, "R7 valid wire", 32'(s_ov), 32'(sv));
            end
            if (P && (model.size() == 0) && sv)
               chk(s_ov && ({s_os, s_od} == {ss, sd}), "R1 same-cycle bypass",
                   32'({s_ov, s_os, s_od}), 32'({1'b1, ss, sd}));
            if (!P && (model.size() == 0))
               chk(s_ov == 1'b0, "R2 no zero-latency output", 32'(s_ov), 32'd0);
            if (sv && s_ir) begin
               model.push_back({ss, sd});
               seq = seq + 8'd1;
            end
            if (s_ov && sr) begin
               if (model.size() == 0) begin
                  chk(1'b0, "R4 output without item", 32'({s_os, s_od}), 32'd0);
               end else begin
                  exp_w = model.pop_front();
                  chk({s_os, s_od} == exp_w, "R4 order and sideband",
                      32'({s_os, s_od}), 32'(exp_w));
               end
            end
            @(negedge clk);
         end
         chk(model.size() == 0, "R4 drained", 32'(model.size()), 32'd0);
         chk(s_ov == 1'b0, "R9 idle after drain", 32'(s_ov), 32'd0);
         g_done[g] = 1'b1;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      mv = 1'b0; mr = 1'b0; md = '0; ms = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(m_ov == 1'b0, "R9 reset state valid", 32'(m_ov), 32'd0);
      rst_n = 1'b1;
      m_rst_n = 1'b1;
      @(negedge clk);

      // Table walk
      for (int i = 0; i < 12; i++) begin
         mv = TBL[i][11];
         mr = TBL[i][10];
         md = 8'h10 + 8'(i);
         ms = md[0];
         #1;
         chk(m_ir == TBL[i][9], $sformatf("R5 table step %0d in_ready", i),
             32'(m_ir), 32'(TBL[i][9]));
         chk(m_ov == TBL[i][8], $sformatf("R3 table step %0d out_valid", i),
             32'(m_ov), 32'(TBL[i][8]));
         if (TBL[i][8])
            chk({m_os, m_od} == {TBL[i][0], TBL[i][7:0]},
                $sformatf("R4 table step %0d data", i),
                32'({m_os, m_od}), 32'({TBL[i][0], TBL[i][7:0]}));
         @(negedge clk);
      end

      // Reset in the middle of a fill: R9
      mv = 1'b1; mr = 1'b0; md = 8'hA5; ms = 1'b1;
      @(negedge clk);
      md = 8'h5A; ms = 1'b0;
      @(negedge clk);
      mv = 1'b0;
      #1;
      chk(m_ir == 1'b0, "R5 full before reset", 32'(m_ir), 32'd0);
      chk(m_od == 8'hA5, "R4 head before reset", 32'(m_od), 32'hA5);
      #1 m_rst_n = 1'b0;
      #1;
      chk(m_ov == 1'b0, "R9 reset discards items", 32'(m_ov), 32'd0);
      chk(m_ir == 1'b1, "R9 ready after reset", 32'(m_ir), 32'd1);
      @(negedge clk);
      m_rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(m_ov == 1'b0, "R9 still empty after release", 32'(m_ov), 32'd0);
      mv = 1'b1; mr = 1'b1; md = 8'h3C; ms = 1'b0;
      #1;
      chk(m_ov && (m_od == 8'h3C), "R1 bypass after reset", 32'(m_od), 32'h3C);
      @(negedge clk);
      mv = 1'b0;

      // R8: depths 0, 1, 2 and 16 run in the stream instances
      for (int g = 0; g < NCFG; g++) wait (g_done[g]);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule